// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a single-cycle 32-bit processor and picks the address of the next instruction on every rising clock edge. The instruction decoder provides a two-bit source select. The datapath provides the sign-extended branch displacement, the 26-bit jump field and the value of the source register. From these the unit forms four candidates: the sequential address, a PC-relative branch address, an absolute address inside the current 256 MB region, and a register-indirect address. It then loads the selected one.

A conditional branch tests one register against zero. A polarity input chooses whether the branch is taken on zero or on nonzero. A branch that is not taken falls through to the sequential address. The sequential address is also driven out combinationally, so the write-back path can store it as the link value for call instructions. All arithmetic wraps modulo 2^32, and no alignment check is made.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` reads 0x00000000. The first edge after release starts from that value.
- R2: With `pc_src_i` = 2'b00, the next `pc_o` is the current `pc_o` + 4, wrapping modulo 2^32 (0xFFFFFFFC becomes 0x00000000).
- R3: `pc_plus4_o` always equals `pc_o` + 4 (mod 2^32) in the same cycle, with no register in between.
- R4: With `pc_src_i` = 2'b01 and `br_on_nonzero_i` = 0, the branch is taken when `rs_val_i` is zero. The next `pc_o` is then `pc_o` + 4 + (`br_offset_i` << 2).
- R5: With `pc_src_i` = 2'b01 and `br_on_nonzero_i` = 1, the branch is taken when `rs_val_i` is nonzero, and the target is the same as in R4.
- R6: A conditional branch whose condition fails loads `pc_o` + 4, whatever the displacement is.
- R7: With `pc_src_i` = 2'b10, the next `pc_o` equals `rs_val_i` exactly, including its two low bits.
- R8: With `pc_src_i` = 2'b11, the next `pc_o` is {current `pc_o`[31:28], `jump_target_i`, 2'b00}.
- R9: A negative displacement moves the PC backwards, with the sum wrapping modulo 2^32. For example, PC 0 with a displacement of -2 gives 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_src_i | input | 2 | Next-PC source: 00 sequential, 01 conditional branch, 10 register, 11 absolute |
| br_on_nonzero_i | input | 1 | Branch polarity: 0 branch on zero, 1 branch on nonzero |
| br_offset_i | input | 32 | Sign-extended branch displacement in words |
| jump_target_i | input | 26 | Absolute jump field in words |
| rs_val_i | input | 32 | Source register value, used for the zero test and the indirect target |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | Current PC + 4, for link write-back |

## Verification
Every fault in this block shows up as a wrong `pc_o` one edge after the cycle whose select exposes it, and the error then persists. It persists because each later expected value is built from the bench's own model of the PC, not from the PC the design reports. A wrong zero test or polarity appears only on branch cycles, and only for the matching register value. A stuck or wrong region field appears only on absolute jumps taken while the upper PC bits are nonzero. For this reason the stimulus first steers the PC into high regions through indirect jumps. A broken incrementer is visible at once on `pc_plus4_o`, in the same cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ  = 2'b00,
    SRC_BR   = 2'b01,
    SRC_REG  = 2'b10,
    SRC_ABS  = 2'b11
  } pc_src_e;
endpackage

// File: rtl/npc_branch_eval.sv
module npc_branch_eval #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] rs_val_i,
  input  logic            on_nonzero_i,
  output logic            taken_o
);
  logic rs_is_zero;

  always_comb begin
    rs_is_zero = (rs_val_i == '0);
    taken_o    = on_nonzero_i ? !rs_is_zero : rs_is_zero;
  end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int XLEN  = 32,
  parameter int JT_W  = 26
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] offset_i,
  input  logic [JT_W-1:0] jfield_i,
  input  logic [XLEN-1:0] rs_val_i,
  output logic [XLEN-1:0] seq_o,
  output logic [XLEN-1:0] rel_o,
  output logic [XLEN-1:0] abs_o,
  output logic [XLEN-1:0] ind_o
);
  localparam int ALIGN_W  = 2;
  localparam int REGION_W = XLEN - JT_W - ALIGN_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(1 << ALIGN_W);

  logic [XLEN-1:0] disp_bytes;

  always_comb begin
    seq_o      = pc_i + STEP;
    disp_bytes = offset_i << ALIGN_W;
    rel_o      = seq_o + disp_bytes;
    ind_o      = rs_val_i;
  end

  generate
    if (REGION_W > 0) begin : g_region
      assign abs_o = {pc_i[XLEN-1 -: REGION_W], jfield_i, {ALIGN_W{1'b0}}};
    end else begin : g_flat
      assign abs_o = XLEN'({jfield_i, {ALIGN_W{1'b0}}});
    end
  endgenerate
endmodule

// File: rtl/npc_target_mux.sv
module npc_target_mux #(
  parameter int XLEN = 32
) (
  input  npc_pkg::pc_src_e sel_i,
  input  logic             taken_i,
  input  logic [XLEN-1:0]  seq_i,
  input  logic [XLEN-1:0]  rel_i,
  input  logic [XLEN-1:0]  abs_i,
  input  logic [XLEN-1:0]  ind_i,
  output logic [XLEN-1:0]  next_o
);
  import npc_pkg::*;

  always_comb begin
    unique case (sel_i)
      SRC_SEQ: next_o = seq_i;
      SRC_BR:  next_o = taken_i ? rel_i : seq_i;
      SRC_REG: next_o = ind_i;
      SRC_ABS: next_o = abs_i;
      default: next_o = seq_i;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int              XLEN     = 32,
  parameter int              JT_W     = 26,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      pc_src_i,
  input  logic            br_on_nonzero_i,
  input  logic [XLEN-1:0] br_offset_i,
  input  logic [JT_W-1:0] jump_target_i,
  input  logic [XLEN-1:0] rs_val_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] pc_plus4_o
);
  import npc_pkg::*;

  localparam int REGION_W = XLEN - JT_W - 2;

  pc_src_e         sel;
  logic            taken;
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] seq_addr, rel_addr, abs_addr, ind_addr;

  assign sel = pc_src_e'(pc_src_i);

  npc_branch_eval #(.XLEN(XLEN)) i_cond (
    .rs_val_i     (rs_val_i),
    .on_nonzero_i (br_on_nonzero_i),
    .taken_o      (taken)
  );

  npc_target_gen #(.XLEN(XLEN), .JT_W(JT_W)) i_tgt (
    .pc_i     (pc_q),
    .offset_i (br_offset_i),
    .jfield_i (jump_target_i),
    .rs_val_i (rs_val_i),
    .seq_o    (seq_addr),
    .rel_o    (rel_addr),
    .abs_o    (abs_addr),
    .ind_o    (ind_addr)
  );

  npc_target_mux #(.XLEN(XLEN)) i_mux (
    .sel_i   (sel),
    .taken_i (taken),
    .seq_i   (seq_addr),
    .rel_i   (rel_addr),
    .abs_i   (abs_addr),
    .ind_i   (ind_addr),
    .next_o  (pc_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign pc_plus4_o = seq_addr;

  // R1
  reset_value_chk: assert property (@(posedge clk) !rst_n |=> pc_o == RESET_PC || !rst_n);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_src_i == 2'b00 |=> pc_o == $past(pc_o) + XLEN'(4));

  // R3
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_plus4_o == pc_o + XLEN'(4));

  // R4
  beqz_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_src_i == 2'b01 && !br_on_nonzero_i && rs_val_i == '0)
    |=> pc_o == $past(pc_o) + XLEN'(4) + ($past(br_offset_i) << 2));

  // R5
  bnez_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_src_i == 2'b01 && br_on_nonzero_i && rs_val_i != '0)
    |=> pc_o == $past(pc_o) + XLEN'(4) + ($past(br_offset_i) << 2));

  // R6
  untaken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_src_i == 2'b01 && (br_on_nonzero_i == (rs_val_i == '0)))
    |=> pc_o == $past(pc_o) + XLEN'(4));

  // R7
  indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_src_i == 2'b10 |=> pc_o == $past(rs_val_i));

  // R8
  abs_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_src_i == 2'b11 |=> (pc_o[XLEN-1 -: REGION_W] == $past(pc_o[XLEN-1 -: REGION_W])
                          && pc_o[JT_W+1:2] == $past(jump_target_i) && pc_o[1:0] == 2'b00));
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  pc_src;
  logic        nz;
  logic [31:0] off;
  logic [25:0] jt;
  logic [31:0] rs;
  logic [31:0] pc, pc4;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] pc_exp;

  always #10 clk = ~clk;

  npc_unit i_npc_unit (
    .clk (clk), .rst_n (rst_n), .pc_src_i (pc_src), .br_on_nonzero_i (nz),
    .br_offset_i (off), .jump_target_i (jt), .rs_val_i (rs),
    .pc_o (pc), .pc_plus4_o (pc4)
  );

  function automatic logic [31:0] model_next(logic [31:0] cur, logic [1:0] s, logic n,
                                             logic [31:0] o, logic [25:0] j, logic [31:0] r);
    logic tk;
    tk = n ? (r != 0) : (r == 0);
    case (s)
      2'b00: return cur + 32'd4;
      2'b01: return tk ? cur + 32'd4 + (o << 2) : cur + 32'd4;
      2'b10: return r;
      default: return {cur[31:28], j, 2'b00};
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [1:0] s, logic n, logic [31:0] r);
    if (s == 2'b00) return "R2";
    if (s == 2'b10) return "R7";
    if (s == 2'b11) return "R8";
    if ((n ? (r != 0) : (r == 0)) == 1'b0) return "R6";
    return n ? "R5" : "R4";
  endfunction

  // starts and ends at a falling edge
  task automatic step(logic [1:0] s, logic n, logic [31:0] o, logic [25:0] j, logic [31:0] r);
    pc_src = s; nz = n; off = o; jt = j; rs = r;
    #1;
    chk("R3", pc4, pc_exp + 32'd4);
    pc_exp = model_next(pc_exp, s, n, o, j, r);
    @(negedge clk);
    chk(tag_of(s, n, r), pc, pc_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd7);
    rst_n = 1'b0; pc_src = 2'b00; nz = 1'b0; off = '0; jt = '0; rs = 32'h1;
    repeat (3) @(negedge clk);
    chk("R1", pc, 32'h0);
    rst_n = 1'b1;
    pc_exp = 32'h0;
    // R2 from reset value
    step(2'b00, 1'b0, 32'h0, 26'h0, 32'h5);
    // R9 backward wrap: pc=4, offset -3 -> 8-12 = FFFFFFFC
    step(2'b01, 1'b0, 32'hFFFF_FFFD, 26'h0, 32'h0);
    chk("R9", pc, 32'hFFFF_FFFC);
    // R2 wrap to zero
    step(2'b00, 1'b0, 32'h0, 26'h0, 32'h0);
    chk("R2", pc, 32'h0);
    // R7 low bits preserved
    step(2'b10, 1'b0, 32'h0, 26'h0, 32'hA000_0013);
    // R8 keeps region A
    step(2'b11, 1'b0, 32'h0, 26'h3FF_FFFF, 32'h0);
    chk("R8", pc, 32'hAFFF_FFFC);
    // R6 untaken with large offset, both polarities
    step(2'b01, 1'b0, 32'h0000_1234, 26'h0, 32'h1);
    step(2'b01, 1'b1, 32'h0000_1234, 26'h0, 32'h0);
    // R5 taken
    step(2'b01, 1'b1, 32'h0000_0010, 26'h0, 32'h8000_0000);
    // R4 taken
    step(2'b01, 1'b0, 32'hFFFF_8000, 26'h0, 32'h0);
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  s;
      logic [15:0] o16;
      logic [31:0] r;
      s   = 2'($urandom);
      o16 = 16'($urandom);
      r   = ($urandom % 3 == 0) ? 32'h0 : $urandom;
      step(s, 1'($urandom), {{16{o16[15]}}, o16}, 26'($urandom), r);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule